// File: doc/BRIEF.md
# Clock Multiplier Control and Lock Timer

This block is the digital control shell around an analog frequency-multiplying PLL. Software writes a configuration word that holds an 8-bit reference divider, an 8-bit multiplier code and a 6-bit settle count. It writes a second mode word that selects an optional halving of the PLL output and enables the lock interrupt. The block divides the main clock down to the PLL reference and drives the divider and multiplier codes to the analog macro. The macro's frequency ratio is (multiplier + 1) / divider; the block does not compute this ratio. The block also drives the macro's enable, which is high whenever the multiplier code is non-zero.

Any write that changes the divider or the multiplier drops the lock status at once. It also restarts a countdown that runs on the slow clock. When the countdown reaches zero, the lock status rises again and, if enabled, so does the interrupt. The reload request travels from the bus clock to the slow clock as a toggle, and the completion flag returns through a two-stage synchronizer. The PLL output clock, supplied from outside, is forwarded downstream either unchanged or divided by two.

Top module: `clkmul_ctrl`

## Requirements
- R1: After reset the divider and multiplier codes are 0, pll_en_o, lock_o and irq_o are low, and ref_clk_o and out_clk_o stay low.
- R2: A write with wr_addr_i=0 loads the divider from data bits [7:0], the multiplier from bits [15:8] and the settle count from bits [21:16]. pll_div_o and pll_mul_o show the loaded codes after the write edge.
- R3: For a divider code N from 1 to 255, ref_clk_o is periodic with a period of exactly N main-clock periods.
- R4: With a divider code of 0, both ref_clk_o and out_clk_o are held constantly low.
- R5: A configuration write whose divider or multiplier differs from the current value makes lock_o low from the clock edge that takes the write.
- R6: After such a change with settle count C, lock_o stays low for at least C+2 slow-clock periods and is high within C+5 slow-clock periods, provided the multiplier is non-zero.
- R7: A configuration write that repeats the current divider and multiplier, including one that changes only the settle count, leaves lock_o high.
- R8: A multiplier code of 0 holds pll_en_o, lock_o and out_clk_o low. Any non-zero multiplier raises pll_en_o.
- R9: A write with wr_addr_i=1 sets the interrupt enable from data bit 1. irq_o is high exactly when lock_o and the interrupt enable are both high.
- R10: Data bit 0 of the mode word selects halving. With it clear, out_clk_o follows pll_clk_i. With it set, out_clk_o has twice the period of pll_clk_i. Both cases need a non-zero divider and multiplier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock for the register writes and the lock status |
| rst_ni | input | 1 | Asynchronous active-low reset; the block synchronizes its release per clock |
| wr_en_i | input | 1 | Write strobe, one bus cycle per write |
| wr_addr_i | input | 1 | 0 selects the configuration word, 1 selects the mode word |
| wr_data_i | input | 22 | Write data |
| mclk_i | input | 1 | Main clock that feeds the reference divider |
| sclk_i | input | 1 | Slow clock that paces the settle countdown |
| pll_clk_i | input | 1 | Output clock of the analog PLL |
| ref_clk_o | output | 1 | Divided reference to the PLL |
| pll_en_o | output | 1 | PLL enable |
| pll_mul_o | output | 8 | Multiplier code to the PLL |
| pll_div_o | output | 8 | Divider code to the PLL |
| lock_o | output | 1 | Lock status |
| irq_o | output | 1 | Lock interrupt |
| out_clk_o | output | 1 | Forwarded PLL clock, optionally halved |

## Verification
The bench builds the block with its default widths: an 8-bit divider, an 8-bit multiplier and a 6-bit settle count. At these widths the divider can be measured at both extremes, 1 and 255, within a short run. The settle count can likewise be swept from 0 to its maximum of 63. The slow clock is set to twenty bus cycles, so the lock bounds of R6 separate by whole slow periods. This makes an error of one count in the countdown, or a skipped synchronizer stage, visible as a lock that rises too early or too late.

// File: rtl/clkmul_pkg.sv
package clkmul_pkg;
  typedef enum logic {
    ADDR_CFG  = 1'b0,
    ADDR_MODE = 1'b1
  } addr_e;

  localparam int HALF_BIT  = 0;
  localparam int IRQEN_BIT = 1;
  localparam int N_DOMAINS = 4;
endpackage

// File: rtl/clkmul_rst_sync.sv
module clkmul_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/clkmul_sync.sv
module clkmul_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/clkmul_regs.sv
module clkmul_regs
  import clkmul_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int MUL_W  = 8,
  parameter int LCNT_W = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic                          wr_addr_i,
  input  logic [DIV_W+MUL_W+LCNT_W-1:0] wr_data_i,
  input  logic                          ack_i,
  input  logic                          done_i,
  output logic [DIV_W-1:0]              div_o,
  output logic [MUL_W-1:0]              mul_o,
  output logic [LCNT_W-1:0]             lcnt_o,
  output logic                          half_o,
  output logic                          irq_en_o,
  output logic                          req_o,
  output logic                          lock_o
);
  localparam int DIV_LSB  = 0;
  localparam int MUL_LSB  = DIV_W;
  localparam int LCNT_LSB = DIV_W + MUL_W;

  logic [DIV_W-1:0]  div_q, div_d, new_div;
  logic [MUL_W-1:0]  mul_q, mul_d, new_mul;
  logic [LCNT_W-1:0] lcnt_q, lcnt_d;
  logic half_q, half_d, irqen_q, irqen_d;
  logic req_q, req_d, pend_q, pend_d, lock_q, lock_d;
  logic wr_cfg, wr_mode, chg, idle, fire;

  always_comb begin
    wr_cfg  = wr_en_i && (wr_addr_i == ADDR_CFG);
    wr_mode = wr_en_i && (wr_addr_i == ADDR_MODE);
    new_div = wr_data_i[DIV_LSB +: DIV_W];
    new_mul = wr_data_i[MUL_LSB +: MUL_W];
    chg     = wr_cfg && ((new_div != div_q) || (new_mul != mul_q));
    idle    = (ack_i == req_q);
    fire    = (chg || pend_q) && idle;

    div_d   = wr_cfg  ? new_div : div_q;
    mul_d   = wr_cfg  ? new_mul : mul_q;
    lcnt_d  = wr_cfg  ? wr_data_i[LCNT_LSB +: LCNT_W] : lcnt_q;
    half_d  = wr_mode ? wr_data_i[HALF_BIT]  : half_q;
    irqen_d = wr_mode ? wr_data_i[IRQEN_BIT] : irqen_q;

    req_d   = req_q ^ fire;
    pend_d  = (chg || pend_q) && !fire;
    lock_d  = !chg && !pend_q && idle && done_i && (mul_q != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      mul_q   <= '0;
      lcnt_q  <= '0;
      half_q  <= 1'b0;
      irqen_q <= 1'b0;
      req_q   <= 1'b0;
      pend_q  <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      div_q   <= div_d;
      mul_q   <= mul_d;
      lcnt_q  <= lcnt_d;
      half_q  <= half_d;
      irqen_q <= irqen_d;
      req_q   <= req_d;
      pend_q  <= pend_d;
      lock_q  <= lock_d;
    end
  end

  assign div_o    = div_q;
  assign mul_o    = mul_q;
  assign lcnt_o   = lcnt_q;
  assign half_o   = half_q;
  assign irq_en_o = irqen_q;
  assign req_o    = req_q;
  assign lock_o   = lock_q;
endmodule

// File: rtl/clkmul_refdiv.sv
module clkmul_refdiv #(
  parameter int DIV_W = 8
) (
  input  logic             mclk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             ref_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             ref_q, ref_d;

  always_comb begin
    if (div_i == '0)                          cnt_d = '0;
    else if (cnt_q >= (div_i - DIV_W'(1)))    cnt_d = '0;
    else                                      cnt_d = cnt_q + 1'b1;
    ref_d = (cnt_d < (div_i >> 1));
  end

  always_ff @(posedge mclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ref_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ref_q <= ref_d;
    end
  end

  assign ref_o = (div_i == DIV_W'(1)) ? mclk_i : ref_q;
endmodule

// File: rtl/clkmul_lock_timer.sv
module clkmul_lock_timer #(
  parameter int LCNT_W = 6
) (
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [LCNT_W-1:0] lcnt_i,
  output logic              ack_o,
  output logic              done_o
);
  logic              req_s, seen_q, ack_q, done_q, done_d, load;
  logic [LCNT_W-1:0] cnt_q, cnt_d;

  clkmul_sync #(.WIDTH(1), .STAGES(2)) u_req_sync (
    .clk_i (sclk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (req_s)
  );

  always_comb begin
    load   = req_s ^ seen_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    if (load) begin
      cnt_d  = lcnt_i;
      done_d = 1'b0;
    end else if (!done_q) begin
      if (cnt_q == '0) done_d = 1'b1;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      ack_q  <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      seen_q <= req_s;
      ack_q  <= seen_q;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign ack_o  = ack_q;
  assign done_o = done_q;
endmodule

// File: rtl/clkmul_postdiv.sv
module clkmul_postdiv (
  input  logic pll_clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic half_i,
  output logic clk_o
);
  logic half_q, half_d;

  always_comb half_d = ~half_q;

  always_ff @(posedge pll_clk_i or negedge rst_ni) begin
    if (!rst_ni) half_q <= 1'b0;
    else         half_q <= half_d;
  end

  assign clk_o = run_i ? (half_i ? half_q : pll_clk_i) : 1'b0;
endmodule

// File: rtl/clkmul_ctrl.sv
module clkmul_ctrl
  import clkmul_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int MUL_W  = 8,
  parameter int LCNT_W = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic                          wr_addr_i,
  input  logic [DIV_W+MUL_W+LCNT_W-1:0] wr_data_i,
  input  logic                          mclk_i,
  input  logic                          sclk_i,
  input  logic                          pll_clk_i,
  output logic                          ref_clk_o,
  output logic                          pll_en_o,
  output logic [MUL_W-1:0]              pll_mul_o,
  output logic [DIV_W-1:0]              pll_div_o,
  output logic                          lock_o,
  output logic                          irq_o,
  output logic                          out_clk_o
);
  logic [N_DOMAINS-1:0] dom_clk, dom_rst_n;
  logic [DIV_W-1:0]     div;
  logic [MUL_W-1:0]     mul;
  logic [LCNT_W-1:0]    lcnt;
  logic half, irq_en, req, ack_s, done_s, ack_raw, done_raw, lock;

  assign dom_clk = {pll_clk_i, sclk_i, mclk_i, clk_i};

  for (genvar g = 0; g < N_DOMAINS; g++) begin : g_rst
    clkmul_rst_sync u_rst (
      .clk_i (dom_clk[g]),
      .rst_ni(rst_ni),
      .rst_no(dom_rst_n[g])
    );
  end

  clkmul_regs #(.DIV_W(DIV_W), .MUL_W(MUL_W), .LCNT_W(LCNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (dom_rst_n[0]),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .ack_i    (ack_s),
    .done_i   (done_s),
    .div_o    (div),
    .mul_o    (mul),
    .lcnt_o   (lcnt),
    .half_o   (half),
    .irq_en_o (irq_en),
    .req_o    (req),
    .lock_o   (lock)
  );

  clkmul_sync #(.WIDTH(2), .STAGES(2)) u_back_sync (
    .clk_i (clk_i),
    .rst_ni(dom_rst_n[0]),
    .d_i   ({ack_raw, done_raw}),
    .q_o   ({ack_s, done_s})
  );

  clkmul_refdiv #(.DIV_W(DIV_W)) u_refdiv (
    .mclk_i(mclk_i),
    .rst_ni(dom_rst_n[1]),
    .div_i (div),
    .ref_o (ref_clk_o)
  );

  clkmul_lock_timer #(.LCNT_W(LCNT_W)) u_timer (
    .sclk_i(sclk_i),
    .rst_ni(dom_rst_n[2]),
    .req_i (req),
    .lcnt_i(lcnt),
    .ack_o (ack_raw),
    .done_o(done_raw)
  );

  clkmul_postdiv u_postdiv (
    .pll_clk_i(pll_clk_i),
    .rst_ni   (dom_rst_n[3]),
    .run_i    ((div != '0) && (mul != '0)),
    .half_i   (half),
    .clk_o    (out_clk_o)
  );

  assign pll_en_o  = (mul != '0);
  assign pll_mul_o = mul;
  assign pll_div_o = div;
  assign lock_o    = lock;
  assign irq_o     = lock & irq_en;
endmodule

// File: rtl/clkmul_ctrl_chk.sv
module clkmul_ctrl_chk #(
  parameter int DIV_W  = 8,
  parameter int MUL_W  = 8,
  parameter int LCNT_W = 6
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          wr_en_i,
  input logic                          wr_addr_i,
  input logic [DIV_W+MUL_W+LCNT_W-1:0] wr_data_i,
  input logic                          pll_en_o,
  input logic [MUL_W-1:0]              pll_mul_o,
  input logic [DIV_W-1:0]              pll_div_o,
  input logic                          lock_o,
  input logic                          irq_o
);
  logic cfg_wr, cfg_diff;
  assign cfg_wr   = wr_en_i && (wr_addr_i == 1'b0);
  assign cfg_diff = (wr_data_i[DIV_W-1:0] != pll_div_o) ||
                    (wr_data_i[DIV_W +: MUL_W] != pll_mul_o);

  a_r5_change_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr && cfg_diff) |=> !lock_o);

  a_r7_same_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr && !cfg_diff && lock_o) |=> lock_o);

  a_r8_lock_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> pll_en_o);

  a_r9_irq_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> lock_o);

  a_r2_codes_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_wr |=> ($stable(pll_div_o) && $stable(pll_mul_o)));
endmodule

bind clkmul_ctrl clkmul_ctrl_chk #(.DIV_W(DIV_W), .MUL_W(MUL_W), .LCNT_W(LCNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .pll_en_o (pll_en_o),
  .pll_mul_o(pll_mul_o),
  .pll_div_o(pll_div_o),
  .lock_o   (lock_o),
  .irq_o    (irq_o)
);

// File: tb/clkmul_ctrl_tb.sv
`timescale 1ns/100ps
module clkmul_ctrl_tb;
  localparam int SLOW_NS = 200;
  localparam int MCLK_NS = 20;
  localparam int PLL_NS  = 6;

  logic clk, rst_n, wr_en, wr_addr, mclk, sclk, pll_clk;
  logic [21:0] wr_data;
  logic ref_clk, pll_en, lock, irq, out_clk;
  logic [7:0] pmul, pdiv;
  int checks = 0;
  int errors = 0;

  clkmul_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .mclk_i(mclk), .sclk_i(sclk), .pll_clk_i(pll_clk),
    .ref_clk_o(ref_clk), .pll_en_o(pll_en), .pll_mul_o(pmul), .pll_div_o(pdiv),
    .lock_o(lock), .irq_o(irq), .out_clk_o(out_clk)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  initial mclk = 1'b0;
  always #(MCLK_NS/2) mclk = ~mclk;
  initial sclk = 1'b0;
  always #(SLOW_NS/2) sclk = ~sclk;
  initial pll_clk = 1'b0;
  always #(PLL_NS/2) pll_clk = ~pll_clk;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    summary();
    $finish;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [21:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [21:0] cfg(input int dv, input int ml, input int cn);
    return {6'(cn), 8'(ml), 8'(dv)};
  endfunction

  function automatic logic pick(input int sel);
    return (sel == 0) ? ref_clk : out_clk;
  endfunction

  // period between 2nd and 3rd rising edge, 0 if none
  task automatic period_of(input int sel, output longint per);
    logic prev;
    int rises = 0;
    longint t1 = 0;
    per = 0;
    #0.5;
    prev = pick(sel);
    for (int i = 0; i < 40000 && rises < 3; i++) begin
      #1;
      if (!prev && pick(sel)) begin
        rises++;
        if (rises == 2) t1 = longint'($time);
        if (rises == 3) per = longint'($time) - t1;
      end
      prev = pick(sel);
    end
  endtask

  // counts samples at which the signal is high during a window
  task automatic highs_in(input int sel, input int ns, output int hits);
    hits = 0;
    #0.5;
    for (int i = 0; i < ns; i++) begin
      #1;
      if (pick(sel)) hits++;
    end
  endtask

  task automatic t_reset();
    int h;
    chk("R1 div", pdiv, 0);
    chk("R1 mul", pmul, 0);
    chk("R1 pll_en", pll_en, 0);
    chk("R1 lock", lock, 0);
    chk("R1 irq", irq, 0);
    highs_in(0, 500, h); chk("R1 ref_clk low", h, 0);
    highs_in(1, 500, h); chk("R1 out_clk low", h, 0);
  endtask

  task automatic t_fields();
    wr(1'b0, cfg(3, 5, 2));
    chk("R2 div field", pdiv, 3);
    chk("R2 mul field", pmul, 5);
    chk("R8 enable on", pll_en, 1);
    wr(1'b0, cfg(3, 0, 2));
    chk("R8 enable off", pll_en, 0);
  endtask

  task automatic t_divider();
    int nlist [5] = '{1, 2, 3, 7, 255};
    longint per;
    foreach (nlist[k]) begin
      wr(1'b0, cfg(nlist[k], 5, 0));
      period_of(0, per);
      chk($sformatf("R3 ref period div=%0d", nlist[k]), per, longint'(nlist[k] * MCLK_NS));
    end
  endtask

  task automatic t_div_zero();
    int h;
    wr(1'b0, cfg(0, 5, 0));
    highs_in(0, 1000, h); chk("R4 ref_clk held low", h, 0);
    highs_in(1, 1000, h); chk("R4 out_clk held low", h, 0);
  endtask

  task automatic lock_cycle(input int dv, input int cn);
    wr(1'b0, cfg(dv, 10, cn));
    chk($sformatf("R5 lock cleared cnt=%0d", cn), lock, 0);
    #((cn + 2) * SLOW_NS - 10);
    chk($sformatf("R6 still unlocked cnt=%0d", cn), lock, 0);
    #(3 * SLOW_NS);
    chk($sformatf("R6 locked cnt=%0d", cn), lock, 1);
  endtask

  task automatic t_lock();
    lock_cycle(4, 0);
    lock_cycle(5, 9);
    lock_cycle(6, 63);
  endtask

  task automatic t_same();
    wr(1'b0, cfg(6, 10, 63));
    chk("R7 identical write keeps lock", lock, 1);
    wr(1'b0, cfg(6, 10, 3));
    chk("R7 count-only write keeps lock", lock, 1);
    #(10 * SLOW_NS);
    chk("R7 lock still high later", lock, 1);
  endtask

  task automatic t_irq();
    chk("R9 irq off while disabled", irq, 0);
    wr(1'b1, 22'h2);
    chk("R9 irq follows lock", irq, 1);
    wr(1'b0, cfg(7, 10, 3));
    chk("R9 irq drops with lock", irq, 0);
    #(8 * SLOW_NS);
    chk("R9 irq back after relock", irq, 1);
    wr(1'b1, 22'h0);
  endtask

  task automatic t_postdiv();
    longint per;
    wr(1'b0, cfg(2, 5, 0));
    period_of(1, per); chk("R10 pass-through period", per, PLL_NS);
    wr(1'b1, 22'h1);
    period_of(1, per); chk("R10 halved period", per, 2 * PLL_NS);
    wr(1'b1, 22'h0);
  endtask

  task automatic t_mul_zero();
    int h;
    #(8 * SLOW_NS);
    chk("R8 locked before disable", lock, 1);
    wr(1'b0, cfg(2, 0, 0));
    chk("R8 pll_en low", pll_en, 0);
    chk("R8 lock low", lock, 0);
    #(10 * SLOW_NS);
    chk("R8 lock stays low", lock, 0);
    highs_in(1, 500, h); chk("R8 out_clk low", h, 0);
    wr(1'b0, cfg(2, 1, 0));
    chk("R8 re-enable", pll_en, 1);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
    #47;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_fields();
    t_divider();
    t_div_zero();
    t_lock();
    t_same();
    t_irq();
    t_postdiv();
    t_mul_zero();
    summary();
    $finish;
  end
endmodule